// File: doc/BRIEF.md
# Cell Overcharge Delay Controller

This block is the digital decision logic behind a secondary overvoltage guard for a stack of two to four series lithium cells. Analog comparators outside the block report, for each cell, whether it sits above the overcharge threshold and whether it sits below the release level. The release level is the threshold less its hysteresis. The block advances once per oscillator tick (one `clk` cycle). It turns those flags into a single active-high charge-cut output that drives the gate of a charge-blocking transistor.

Detection is filtered by a qualification counter. The counter keeps running through brief dropouts and restarts only after a sustained one. Release is filtered by its own, shorter counter. Three build variants are chosen by a parameter:
- Non-latching, with a floating control input resolved low.
- Non-latching, with a floating control input resolved high.
- Latching, cleared by a rising control edge.

In both non-latching variants a low control input forces the output on. A hidden test mode, entered by holding a request line, shortens only the detection delay. It ends by itself after one detection or on undervoltage lockout.

Top module: `ovc_guard`

## Requirements
- R1: When any bit of `over_i` has been high on DET_TICKS consecutive ticks, counted from the first such tick, `chg_cut_o` is 1 after the DET_TICKS-th rising edge and was 0 after the one before.
- R2: During a detection count, a gap with all of `over_i` low that lasts fewer than TR_TICKS ticks does not stop the count; the gap ticks are counted too. A gap of TR_TICKS ticks clears the count, and the next over-threshold tick starts again from zero.
- R3: Once detected, the overcharge state is released only after all bits of `below_i` have been high for REL_TICKS consecutive ticks. A single low bit restarts the wait. After release, the non-latching variants drive `chg_cut_o` low, provided the control input is high.
- R4: In the non-latching variants (VARIANT 0 = VAR_PULLDN, 1 = VAR_PULLUP), a resolved control level of 0 forces `chg_cut_o` to 1 two ticks after it is applied. The resolved level is `ctl_i`, or a fixed value while `ctl_open_i` = 1: 0 for VAR_PULLDN and 1 for VAR_PULLUP. While the resolved level is 1, the output follows the overcharge state.
- R5: In the latching variant (VARIANT 2 = VAR_LATCH, floating level 0), `chg_cut_o` stays 1 after release. It is cleared by a rising edge of the two-flop-synchronized control level, meaning a 0 on one tick followed by a 1 on the next. The edge counts only if the overcharge state has already been released; an edge seen before release is ignored.
- R6: In the latching variant, `uvlo_i` = 1 clears `chg_cut_o` on the next tick.
- R7: Test mode is entered after `test_req_i` has been high for TST_TICKS consecutive ticks. A shorter request has no effect. Once entered, test mode persists after the request drops.
- R8: In test mode the detection delay is DET_TEST_TICKS ticks. The release delay stays REL_TICKS and the gap window stays TR_TICKS.
- R9: Test mode ends on the tick a detection completes, or on any tick with `uvlo_i` = 1; the next detection then takes DET_TICKS.
- R10: Synchronous reset `rst` clears all counters, the test-mode flag, the overcharge state and the latch, and leaves `chg_cut_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator tick clock |
| rst | input | 1 | Synchronous active-high reset (also power-up lockout) |
| over_i | input | NCELL | Per-cell flag: cell above overcharge threshold |
| below_i | input | NCELL | Per-cell flag: cell below release level |
| ctl_i | input | 1 | Control input level |
| ctl_open_i | input | 1 | Control input left floating; level taken from the variant's pull |
| uvlo_i | input | 1 | Supply undervoltage lockout flag |
| test_req_i | input | 1 | Test-mode entry request |
| chg_cut_o | output | 1 | Active-high charge-cut output |

## Verification
Two events can land on the same tick: a detection completing in test mode and the exit from test mode. The detection must use the short limit, and the test flag must clear at that same edge. The bench provokes this by entering test mode, raising one cell flag, and expecting the output after DET_TEST_TICKS. It then re-arms the cell and expects the full DET_TICKS, which exposes a test flag that survived the firing tick. A second collision is a control rising edge that lands while the release count is still running. The bench times the edge to arrive one tick before release qualifies and checks that the latched output stays high afterward.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic [1:0] {
        VAR_PULLDN = 2'd0,
        VAR_PULLUP = 2'd1,
        VAR_LATCH  = 2'd2
    } variant_e;

    // Level a floating control input settles to for each build variant
    function automatic logic float_level(variant_e v);
        return (v == VAR_PULLUP);
    endfunction

endpackage

// File: rtl/ovc_ctl_sync.sv
module ovc_ctl_sync (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = lvl_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        else     s_q <= s_d;
    end

    assign lvl_o  = s_q.sync;
    assign rise_o = s_q.sync & ~s_q.prev;

    // A synchronized level change always travels through the first stage
    assert_sync_path_R4: assert property (@(posedge clk) disable iff (rst)
        (s_q.meta != s_q.sync) |=> (lvl_o == $past(s_q.meta)));
endmodule

// File: rtl/ovc_detect.sv
module ovc_detect #(
    parameter int DET_TICKS      = 8000,
    parameter int DET_TEST_TICKS = 128,
    parameter int TR_TICKS       = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fast_i,
    input  logic any_over_i,
    output logic fire_o
);
    localparam int DW = $clog2(DET_TICKS + 1);
    localparam int GW = $clog2(TR_TICKS + 1);
    localparam logic [DW-1:0] LAST_NORM = DW'(DET_TICKS - 1);
    localparam logic [DW-1:0] LAST_FAST = DW'(DET_TEST_TICKS - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(TR_TICKS - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [GW-1:0] gap;
    } det_t;

    det_t d_d, d_q;
    logic [DW-1:0] last;
    logic fire;

    always_comb begin
        d_d  = d_q;
        fire = 1'b0;
        last = fast_i ? LAST_FAST : LAST_NORM;
        if (!en_i) begin
            d_d = '0;
        end else if (any_over_i) begin
            d_d.gap = '0;
            if (d_q.cnt >= last) begin
                fire    = 1'b1;
                d_d.cnt = '0;
            end else begin
                d_d.cnt = d_q.cnt + 1'b1;
            end
        end else if (d_q.cnt != '0) begin
            if (d_q.gap == GAP_LAST) begin
                d_d = '0;
            end else begin
                d_d.gap = d_q.gap + 1'b1;
                if (d_q.cnt < last) d_d.cnt = d_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign fire_o = fire;

    assert_gap_bound_R2: assert property (@(posedge clk) disable iff (rst)
        d_q.gap <= GAP_LAST);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        d_q.cnt <= LAST_NORM);
    assert_count_runs_R1: assert property (@(posedge clk) disable iff (rst)
        (en_i && any_over_i && !fire_o) |=> (d_q.cnt != '0));
endmodule

// File: rtl/ovc_release.sv
module ovc_release #(
    parameter int REL_TICKS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic all_below_i,
    output logic fire_o
);
    localparam int RW = $clog2(REL_TICKS + 1);
    localparam logic [RW-1:0] REL_LAST = RW'(REL_TICKS - 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } rel_t;

    rel_t r_d, r_q;
    logic fire;

    always_comb begin
        r_d  = r_q;
        fire = 1'b0;
        if (!en_i || !all_below_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == REL_LAST) begin
            fire    = 1'b1;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign fire_o = fire;

    assert_release_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (en_i && !all_below_i) |=> (r_q.cnt == '0));
endmodule

// File: rtl/ovc_testmode.sv
module ovc_testmode #(
    parameter int TST_TICKS = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic exit_i,
    output logic active_o
);
    localparam int TW = $clog2(TST_TICKS + 1);
    localparam logic [TW-1:0] TST_LAST = TW'(TST_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          on;
    } tm_t;

    tm_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (exit_i) begin
            t_d = '0;
        end else if (t_q.on || !req_i) begin
            t_d.cnt = '0;
        end else if (t_q.cnt == TST_LAST) begin
            t_d.on  = 1'b1;
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign active_o = t_q.on;

    assert_entry_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> $past(req_i));
    assert_mode_persists_R7: assert property (@(posedge clk) disable iff (rst)
        (active_o && !exit_i) |=> active_o);
    assert_mode_exit_R9: assert property (@(posedge clk) disable iff (rst)
        exit_i |=> !active_o);
endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
    import ovc_pkg::*;
#(
    parameter int       NCELL          = 4,
    parameter variant_e VARIANT        = VAR_PULLDN,
    parameter int       DET_TICKS      = 8000,
    parameter int       DET_TEST_TICKS = 128,
    parameter int       TR_TICKS       = 24,
    parameter int       REL_TICKS      = 128,
    parameter int       TST_TICKS      = 160
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCELL-1:0] over_i,
    input  logic [NCELL-1:0] below_i,
    input  logic             ctl_i,
    input  logic             ctl_open_i,
    input  logic             uvlo_i,
    input  logic             test_req_i,
    output logic             chg_cut_o
);
    localparam logic IS_LATCH  = (VARIANT == VAR_LATCH);
    localparam logic FLOAT_LVL = float_level(VARIANT);

    typedef struct packed {
        logic ovc;
        logic hold;
    } top_t;

    top_t s_d, s_q;
    logic ctl_lvl, ctl_s, ctl_rise;
    logic det_fire, rel_fire, tmode;

    assign ctl_lvl = ctl_open_i ? FLOAT_LVL : ctl_i;

    ovc_ctl_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (ctl_lvl),
        .lvl_o  (ctl_s),
        .rise_o (ctl_rise)
    );

    ovc_detect #(
        .DET_TICKS      (DET_TICKS),
        .DET_TEST_TICKS (DET_TEST_TICKS),
        .TR_TICKS       (TR_TICKS)
    ) u_det (
        .clk        (clk),
        .rst        (rst),
        .en_i       (!s_q.ovc),
        .fast_i     (tmode),
        .any_over_i (|over_i),
        .fire_o     (det_fire)
    );

    ovc_release #(.REL_TICKS(REL_TICKS)) u_rel (
        .clk         (clk),
        .rst         (rst),
        .en_i        (s_q.ovc),
        .all_below_i (&below_i),
        .fire_o      (rel_fire)
    );

    ovc_testmode #(.TST_TICKS(TST_TICKS)) u_tm (
        .clk      (clk),
        .rst      (rst),
        .req_i    (test_req_i),
        .exit_i   (det_fire | uvlo_i),
        .active_o (tmode)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovc = s_q.ovc ? !rel_fire : det_fire;
        if (IS_LATCH) begin
            if (uvlo_i)                      s_d.hold = 1'b0;
            else if (det_fire)               s_d.hold = 1'b1;
            else if (ctl_rise && !s_q.ovc)   s_d.hold = 1'b0;
        end else begin
            s_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign chg_cut_o = IS_LATCH ? s_q.hold : (s_q.ovc | ~ctl_s);

    assert_reset_low_R10: assert property (@(posedge clk)
        rst |=> !chg_cut_o);
    assert_latch_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (IS_LATCH && chg_cut_o && !uvlo_i && !ctl_rise) |=> chg_cut_o);
    assert_early_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (IS_LATCH && chg_cut_o && s_q.ovc && !uvlo_i) |=> chg_cut_o);
    assert_uvlo_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (IS_LATCH && uvlo_i) |=> !chg_cut_o);
endmodule

// File: tb/ovc_guard_test.sv
module ovc_guard_test;
    import ovc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int DET  = 20;
    localparam int DETT = 5;
    localparam int TR   = 4;
    localparam int REL  = 6;
    localparam int TST  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0] over = '0;
    logic [NC-1:0] below = '0;
    logic ctl = 1'b1;
    logic ctl_open = 1'b0;
    logic uvlo = 1'b0;
    logic treq = 1'b0;
    logic out_pd, out_pu, out_lat;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ovc_guard #(.NCELL(NC), .VARIANT(VAR_PULLDN), .DET_TICKS(DET), .DET_TEST_TICKS(DETT),
                .TR_TICKS(TR), .REL_TICKS(REL), .TST_TICKS(TST)) uut (
        .clk(clk), .rst(rst), .over_i(over), .below_i(below), .ctl_i(ctl),
        .ctl_open_i(ctl_open), .uvlo_i(uvlo), .test_req_i(treq), .chg_cut_o(out_pd));

    ovc_guard #(.NCELL(NC), .VARIANT(VAR_PULLUP), .DET_TICKS(DET), .DET_TEST_TICKS(DETT),
                .TR_TICKS(TR), .REL_TICKS(REL), .TST_TICKS(TST)) uut_pu (
        .clk(clk), .rst(rst), .over_i(over), .below_i(below), .ctl_i(ctl),
        .ctl_open_i(ctl_open), .uvlo_i(uvlo), .test_req_i(treq), .chg_cut_o(out_pu));

    ovc_guard #(.NCELL(NC), .VARIANT(VAR_LATCH), .DET_TICKS(DET), .DET_TEST_TICKS(DETT),
                .TR_TICKS(TR), .REL_TICKS(REL), .TST_TICKS(TST)) uut_lat (
        .clk(clk), .rst(rst), .over_i(over), .below_i(below), .ctl_i(ctl),
        .ctl_open_i(ctl_open), .uvlo_i(uvlo), .test_req_i(treq), .chg_cut_o(out_lat));

    typedef struct {
        logic  pd;
        logic  pu;
        logic  lat;
        string tag;
    } exp_t;

    exp_t sb[$];
    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect3(input logic pd, input logic pu, input logic lat, input string tag);
        exp_t e;
        e.pd = pd; e.pu = pu; e.lat = lat; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic release_and_clear();
        over = '0; below = '1;
        tick(REL);
        ctl = 1'b0; tick(2);
        ctl = 1'b1; tick(3);
        expect3(1'b0, 1'b0, 1'b0, "R5 latch cleared by edge after release");
    endtask

    // Monitor: compares the queued expectations just after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (out_pd !== e.pd || out_pu !== e.pu || out_lat !== e.lat) begin
                n_fail++;
                $display("FAIL %s: got pd=%b pu=%b lat=%b expected pd=%b pu=%b lat=%b",
                         e.tag, out_pd, out_pu, out_lat, e.pd, e.pu, e.lat);
            end
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect3(1'b0, 1'b0, 1'b0, "R10 reset state");

        // R1 basic detection
        over = 4'b0100;
        tick(DET - 1); expect3(1'b0, 1'b0, 1'b0, "R1 one tick before delay");
        tick(1);       expect3(1'b1, 1'b1, 1'b1, "R1 detection delay reached");

        // R3 release filter
        over = '0; below = 4'b0111;
        tick(10);      expect3(1'b1, 1'b1, 1'b1, "R3 one cell not below release");
        below = '1;
        tick(REL - 1); expect3(1'b1, 1'b1, 1'b1, "R3 release delay not yet met");
        tick(1);       expect3(1'b0, 1'b0, 1'b1, "R3 release qualified");

        // R4 override and R5 edge clear
        ctl = 1'b0;
        tick(1);       expect3(1'b0, 1'b0, 1'b1, "R4 synchronizer latency");
        tick(1);       expect3(1'b1, 1'b1, 1'b1, "R4 low control forces output");
        ctl = 1'b1;
        tick(2);       expect3(1'b0, 1'b0, 1'b1, "R5 latch waits for edge");
        tick(1);       expect3(1'b0, 1'b0, 1'b0, "R5 rising edge clears latch");

        // R4 floating control
        ctl_open = 1'b1;
        tick(2);       expect3(1'b1, 1'b0, 1'b0, "R4 floating resolves per variant");
        ctl_open = 1'b0;
        tick(2);       expect3(1'b0, 1'b0, 1'b0, "R4 driven high again");

        // R2 short dip keeps the count
        over = 4'b0001; below = '0;
        tick(8);
        over = '0;
        tick(TR - 1);  expect3(1'b0, 1'b0, 1'b0, "R2 during short dip");
        over = 4'b0001;
        tick(8);       expect3(1'b0, 1'b0, 1'b0, "R2 before total delay");
        tick(1);       expect3(1'b1, 1'b1, 1'b1, "R2 short dip counted through");
        release_and_clear();

        // R2 long dip restarts the count
        over = 4'b1000; below = '0;
        tick(8);
        over = '0;
        tick(TR);
        over = 4'b1000;
        tick(DET - 1); expect3(1'b0, 1'b0, 1'b0, "R2 long dip restarted count");
        tick(1);       expect3(1'b1, 1'b1, 1'b1, "R2 fire after restart");

        // R5 edge arriving before release is ignored
        over = '0; below = '1; ctl = 1'b0;
        tick(2);
        ctl = 1'b1;
        tick(3);       expect3(1'b1, 1'b1, 1'b1, "R3 release still pending");
        tick(1);       expect3(1'b0, 1'b0, 1'b1, "R5 early edge ignored");
        tick(3);       expect3(1'b0, 1'b0, 1'b1, "R5 latch still held");

        // R6 undervoltage lockout clears latch
        uvlo = 1'b1;
        tick(1);       expect3(1'b0, 1'b0, 1'b0, "R6 lockout clears latch");
        uvlo = 1'b0;

        // R7 short request does not enter test mode
        treq = 1'b1; tick(TST - 1);
        treq = 1'b0; tick(1);
        over = 4'b0010; below = '0;
        tick(DETT);    expect3(1'b0, 1'b0, 1'b0, "R7 short request ignored");
        tick(DET - DETT); expect3(1'b1, 1'b1, 1'b1, "R7 normal delay kept");
        release_and_clear();

        // R7 entry and R8 shortened detection
        treq = 1'b1; tick(TST);
        treq = 1'b0; tick(3);
        over = 4'b0010; below = '0;
        tick(DETT - 1); expect3(1'b0, 1'b0, 1'b0, "R8 before short delay");
        tick(1);       expect3(1'b1, 1'b1, 1'b1, "R8 R7 test mode shortens detection");
        over = '0; below = '1;
        tick(REL - 1); expect3(1'b1, 1'b1, 1'b1, "R8 release not shortened");
        tick(1);       expect3(1'b0, 1'b0, 1'b1, "R8 release at normal delay");
        ctl = 1'b0; tick(2);
        ctl = 1'b1; tick(3);
        expect3(1'b0, 1'b0, 1'b0, "R5 latch cleared after test release");

        // R9 exit on detection
        over = 4'b0010; below = '0;
        tick(DETT);    expect3(1'b0, 1'b0, 1'b0, "R9 test mode left after fire");
        tick(DET - DETT); expect3(1'b1, 1'b1, 1'b1, "R9 full delay restored");
        release_and_clear();

        // R9 exit on lockout
        treq = 1'b1; tick(TST);
        treq = 1'b0;
        uvlo = 1'b1; tick(1);
        uvlo = 1'b0;
        over = 4'b0001; below = '0;
        tick(DETT);    expect3(1'b0, 1'b0, 1'b0, "R9 lockout ends test mode");
        tick(DET - DETT); expect3(1'b1, 1'b1, 1'b1, "R9 full delay after lockout");

        // R10 reset mid-run
        over = '0;
        rst = 1'b1;
        tick(1);       expect3(1'b0, 1'b0, 1'b0, "R10 reset clears held output");
        rst = 1'b0;
        tick(2);       expect3(1'b0, 1'b0, 1'b0, "R10 stays low after reset");

        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule